// File: doc/BRIEF.md
# Edge-Sensing Phase-Frequency Detector with Three-State Output

This block compares two digital signals for a phase-locked loop and reports the sign of their phase error. The two signals are a reference and a feedback signal coming back from the oscillator or a divider. Both inputs are asynchronous to the system clock. Each one passes through a synchroniser and then a rising-edge detector. Only rising edges change the detector state.

The error output is three-state. It is presented as a drive-high line, a drive-low line and an output enable, which an I/O cell or a charge-pump model can combine. A reference edge that arrives first pushes the error output high until the next feedback edge arrives. A feedback edge that arrives first pulls the error output low until the next reference edge arrives. The rest of the time the output floats. A lock pulse output is high exactly while the output floats, so a loop that is in lock shows long stretches of lock pulse broken only by short corrections.

Top module: `tristate_pfd`

## Requirements
- R1: While `rst_n` is low at a clock edge, the detector goes idle: `out_en`, `drive_hi` and `drive_lo` are 0 and `lock_pulse` is 1.
- R2: A reference rising edge while idle, with no feedback edge in the same cycle, makes `drive_hi`=1, `drive_lo`=0, `out_en`=1.
- R3: A feedback rising edge while idle, with no reference edge in the same cycle, makes `drive_lo`=1, `drive_hi`=0, `out_en`=1.
- R4: While driving high, the next feedback rising edge returns the detector to idle. While driving low, the next reference rising edge returns it to idle.
- R5: `lock_pulse` is 1 exactly when `out_en` is 0. `drive_hi` and `drive_lo` are never 1 together, and neither is 1 while `out_en` is 0.
- R6: Falling edges and held levels on either input leave every output unchanged, so the input duty cycle has no effect.
- R7: Further rising edges on the input that started the current drive leave the drive unchanged.
- R8: When both inputs show a rising edge in the same detector cycle, the detector ends in idle, whatever state it was in.
- R9: An input change made between clock edges reaches the outputs after the third rising clock edge that follows it (two synchroniser stages plus the state register), with the default of two synchroniser stages.
- R10: When only feedback edges arrive and the reference is silent, the output stays driven low for as long as that lasts.
- R11: A reference pulse one clock cycle wide, such as a noise spike, counts as a full rising edge and drives the output high until the next feedback edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback (comparison) signal, asynchronous |
| drive_hi | output | 1 | Error output driven high |
| drive_lo | output | 1 | Error output driven low |
| out_en | output | 1 | Error output enable, 0 means high impedance |
| lock_pulse | output | 1 | High while the error output is high impedance |

## Verification
The bench raises both inputs in the same cycle, once from idle, once while driving high and once while driving low. A design that gave one input priority would be left driving instead of idle. It holds levels high and then drops them, which catches a level-sensitive or falling-edge-sensitive design: such a design would change state when the duty cycle changes. It also repeats edges on the input that started a drive, sends a one-cycle reference spike, and sends a long run of feedback edges with no reference. A design that toggled on repeats, missed narrow pulses or drifted back to high impedance would fail those cases. Each check samples exactly three edges after the input change, so a design with one register too many or too few also fails.

// File: rtl/tristate_pfd_pkg.sv
// Shared types for the phase-frequency detector.
package tristate_pfd_pkg;
    // Detector state: floating, pushing the loop up, or pulling it down.
    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DOWN = 2'd2
    } pfd_state_t;
endpackage

// File: rtl/tristate_pfd_sync_edge.sv
// Synchroniser with rising-edge detector for a single asynchronous input.
// Assumes STAGES >= 2. The rise output is high for one clock cycle and
// comes STAGES-1 cycles after the first capture of a new high level.
module tristate_pfd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe;

    // Shift the input through the synchroniser and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    // A rising edge is a new high level behind an old low one.
    always_comb rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tristate_pfd_fsm.sv
// Three-state detector core. It acts only on one-cycle rise strobes.
// A rise on one input starts a drive, and a rise on the other input ends it.
// Rises on both inputs in the same cycle always lead to idle.
module tristate_pfd_fsm
    import tristate_pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_rise,
    input  logic       fb_rise,
    output pfd_state_t state
);
    pfd_state_t nxt;

    // Next-state selection from the current state and the two strobes.
    always_comb begin
        nxt = state;
        unique case (state)
            PFD_IDLE: begin
                if (ref_rise && !fb_rise)      nxt = PFD_UP;
                else if (fb_rise && !ref_rise) nxt = PFD_DOWN;
            end
            PFD_UP:   if (fb_rise)  nxt = PFD_IDLE;
            PFD_DOWN: if (ref_rise) nxt = PFD_IDLE;
            default:  nxt = PFD_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PFD_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/tristate_pfd.sv
// Top of the edge-sensing phase-frequency detector. Assumes both inputs
// are asynchronous to clk, and that each stays in one level for at least
// one clock period so that the synchroniser captures it.
module tristate_pfd
    import tristate_pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic drive_hi,
    output logic drive_lo,
    output logic out_en,
    output logic lock_pulse
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_vec;
    logic [NUM_IN-1:0] rise_vec;
    logic              ref_rise;
    logic              fb_rise;
    pfd_state_t        state;

    // Bundle the inputs so that one generate loop builds both front ends.
    always_comb raw_vec = {fb_in, ref_in};

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_front
        tristate_pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(raw_vec[gi]),
            .rise    (rise_vec[gi])
        );
    end

    // Name the strobes for the core and the checker.
    always_comb begin
        ref_rise = rise_vec[0];
        fb_rise  = rise_vec[1];
    end

    tristate_pfd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_rise(ref_rise),
        .fb_rise (fb_rise),
        .state   (state)
    );

    // Decode the registered state into the three-state pins and lock flag.
    always_comb begin
        drive_hi   = (state == PFD_UP);
        drive_lo   = (state == PFD_DOWN);
        out_en     = (state != PFD_IDLE);
        lock_pulse = (state == PFD_IDLE);
    end
endmodule

// File: rtl/tristate_pfd_checker.sv
// Protocol checker for tristate_pfd. It watches the rise strobes and the
// output pins and is attached with the bind statement at the end of the file.
module tristate_pfd_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_rise,
    input logic fb_rise,
    input logic drive_hi,
    input logic drive_lo,
    input logic out_en,
    input logic lock_pulse
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (lock_pulse && !out_en && !drive_hi && !drive_lo));

    assert_ref_starts_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && ref_rise && !fb_rise) |=> (drive_hi && out_en));

    assert_fb_starts_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && fb_rise && !ref_rise) |=> (drive_lo && out_en));

    assert_up_ends_on_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_hi && fb_rise) |=> !out_en);

    assert_down_ends_on_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_lo && ref_rise) |=> !out_en);

    assert_lock_is_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_pulse != out_en) && !(drive_hi && drive_lo)
        && ((drive_hi || drive_lo) == out_en));

    assert_quiet_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_rise && !fb_rise) |=> ($stable(drive_hi) && $stable(drive_lo)
                                      && $stable(out_en)));

    assert_repeat_ref_keeps_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_hi && !fb_rise) |=> drive_hi);

    assert_repeat_fb_keeps_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_lo && !ref_rise) |=> drive_lo);

    assert_both_edges_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && fb_rise) |=> !out_en);
endmodule

bind tristate_pfd tristate_pfd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_rise  (ref_rise),
    .fb_rise   (fb_rise),
    .drive_hi  (drive_hi),
    .drive_lo  (drive_lo),
    .out_en    (out_en),
    .lock_pulse(lock_pulse)
);

// File: tb/tristate_pfd_test.sv
`timescale 1ns/1ps
module tristate_pfd_test;
    localparam logic [1:0] S_IDLE = 2'd0;
    localparam logic [1:0] S_UP   = 2'd1;
    localparam logic [1:0] S_DN   = 2'd2;
    localparam int NVEC = 22;
    localparam int HOLD = 4;   // cycles per vector; the outputs settle after 3

    // Each vector is {ref level, fb level, expected state, requirement number}.
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b0, 1'b0, S_IDLE, 4'd1},   // R1 quiet after reset
        {1'b1, 1'b0, S_UP,   4'd2},   // R2 ref rise
        {1'b0, 1'b0, S_UP,   4'd6},   // R6 ref fall ignored
        {1'b1, 1'b0, S_UP,   4'd7},   // R7 repeated ref rise
        {1'b1, 1'b1, S_IDLE, 4'd4},   // R4 fb rise ends up
        {1'b0, 1'b1, S_IDLE, 4'd6},   // R6 ref fall ignored
        {1'b0, 1'b0, S_IDLE, 4'd6},   // R6 fb fall ignored
        {1'b0, 1'b1, S_DN,   4'd3},   // R3 fb rise
        {1'b0, 1'b0, S_DN,   4'd6},   // R6
        {1'b0, 1'b1, S_DN,   4'd7},   // R7 repeated fb rise
        {1'b1, 1'b1, S_IDLE, 4'd4},   // R4 ref rise ends down
        {1'b0, 1'b0, S_IDLE, 4'd6},   // R6
        {1'b1, 1'b1, S_IDLE, 4'd8},   // R8 both from idle
        {1'b0, 1'b0, S_IDLE, 4'd6},   // R6
        {1'b1, 1'b0, S_UP,   4'd2},   // R2
        {1'b0, 1'b0, S_UP,   4'd6},   // R6
        {1'b1, 1'b1, S_IDLE, 4'd8},   // R8 both while up
        {1'b0, 1'b0, S_IDLE, 4'd6},   // R6
        {1'b0, 1'b1, S_DN,   4'd3},   // R3
        {1'b0, 1'b0, S_DN,   4'd6},   // R6
        {1'b1, 1'b1, S_IDLE, 4'd8},   // R8 both while down
        {1'b0, 1'b0, S_IDLE, 4'd5}    // R5 lock flag back
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic drive_hi, drive_lo, out_en, lock_pulse;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    tristate_pfd uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .drive_hi(drive_hi), .drive_lo(drive_lo),
        .out_en(out_en), .lock_pulse(lock_pulse)
    );

    // Compare the pins with the pattern that the expected state implies.
    task automatic check(input logic [1:0] exp, input int req, input string what);
        logic [3:0] want, got;
        case (exp)
            S_UP:    want = 4'b1010;
            S_DN:    want = 4'b0110;
            default: want = 4'b0001;
        endcase
        got = {drive_hi, drive_lo, out_en, lock_pulse};
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL R%0d %s: {hi,lo,en,lock} got %b expected %b", req, what, got, want);
        end
    endtask

    // Drive levels at a falling edge, wait, then sample at a falling edge.
    task automatic apply(input logic r, input logic f, input int cycles);
        @(negedge clk);
        ref_in = r;
        fb_in  = f;
        repeat (cycles - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(S_IDLE, 1, "held in reset");                 // R1
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][7], VEC[i][6], HOLD);
            check(VEC[i][5:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end

        // R9: exact latency. The outputs must not move after two edges but must after three.
        @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(S_IDLE, 9, "two edges after ref rise");
        @(negedge clk);
        check(S_UP, 9, "three edges after ref rise");

        // R1: reset in the middle of a drive.
        rst_n = 1'b0;
        ref_in = 1'b0;
        @(negedge clk);
        check(S_IDLE, 1, "reset while driving high");
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 1'b0, HOLD);
        check(S_IDLE, 1, "quiet after reset release");

        // R10: feedback edges only, the reference stays silent.
        for (int k = 0; k < 6; k++) begin
            apply(1'b0, 1'b1, 2);
            apply(1'b0, 1'b0, 2);
            check(S_DN, 10, $sformatf("fb-only pulse %0d", k));
        end
        apply(1'b1, 1'b0, HOLD);
        check(S_IDLE, 4, "ref rise ends long down");        // R4
        apply(1'b0, 1'b0, HOLD);

        // R11: a reference spike one clock wide is taken as an edge.
        apply(1'b1, 1'b0, 1);
        apply(1'b0, 1'b0, HOLD);
        check(S_UP, 11, "one-cycle ref spike");
        apply(1'b0, 1'b1, HOLD);
        check(S_IDLE, 11, "fb rise after spike");
        apply(1'b0, 1'b0, HOLD);
        check(S_IDLE, 6, "fb fall after spike");            // R6

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule